// File: doc/BRIEF.md
# SDRAM Single-Bank Command Sequencer

This block sits between a local request port and one bank of an SDRAM device. A user presents a read or a write with an address. The block takes it when its ready output is high. It then emits the memory commands the access needs: precharge, activate, read or write. Each command is held back until the timing gaps that apply to it have run out. The block keeps a record of the row that is open in the bank. From that record it picks one of three paths: a direct access when the row is already open, an activate followed by the access when no row is open, or a precharge, an activate and then the access when a different row is open.

A read placed right after a write to the open row waits out the write-to-read turnaround. A read that misses the open row after a write instead waits for write recovery before its precharge. The miss path does not add the turnaround on top, because its own chain of gaps is longer. The block returns read data with a one-cycle strobe a fixed CAS latency after each read command. All gaps are compile-time parameters counted in clock cycles. The bank comes out of reset idle, with no row open.

Top module: `sdram_bank_seq`

## Requirements
- R1: A request is taken only in a cycle where both `req_i` and `ready_o` are high. `ready_o` goes low in the next cycle and stays low until the cycle in which the read or write command for that request appears. A request raised while `ready_o` is low has no effect.
- R2: After reset, `ready_o` is high, `cmd_o` is NOP, `rd_valid_o` is low and no row is open.
- R3: `cmd_o` encodes NOP=0, precharge=1, activate=2, read=3, write=4, with at most one command per cycle. The request address splits into the row (upper `ROW_W` bits) and the column (lower `COL_W` bits). Activate drives the row on `cmd_row_o`. Read and write drive the column on `cmd_col_o`. Write also drives the request data on `cmd_wdata_o`.
- R4: A request to a bank with no open row issues an activate of its row and then the access, with no precharge.
- R5: A request to the open row issues only the access command.
- R6: A request to a different row issues precharge, then activate of the new row, then the access.
- R7: A precharge comes no earlier than `T_WR` cycles after the latest write command.
- R8: An activate comes no earlier than `T_RP` cycles after the latest precharge.
- R9: A read or write comes no earlier than `T_RCD` cycles after the latest activate.
- R10: A read that hits the open row comes no earlier than `T_WTR` cycles after the latest write. A read on the miss path is not held for `T_WTR` separately.
- R11: `rd_valid_o` is high for one cycle exactly `CL` cycles after each read command. In that cycle, `rd_data_o` equals `mem_rdata_i`.
- R12: Each command issues at the earliest cycle that the rules allow. That cycle is no sooner than two cycles after acceptance, and never more than one command per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Request address, row above column |
| req_wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Block can take a request |
| cmd_o | output | 3 | Memory command code |
| cmd_row_o | output | ROW_W | Row carried by activate |
| cmd_col_o | output | COL_W | Column carried by read/write |
| cmd_wdata_o | output | DATA_W | Data carried by write |
| mem_rdata_i | input | DATA_W | Data returned by the memory |
| rd_valid_o | output | 1 | Read data strobe |
| rd_data_o | output | DATA_W | Read data |

## Verification
A corrupted open-row record shows up at `cmd_o` within two cycles of the next acceptance. It appears either as a missing or an extra precharge/activate, or as an activate carrying the wrong row. A gap counter that loads the wrong value or misses a load shifts a command by one or more cycles. The bench catches this because it predicts the exact issue cycle of every command, not just a lower bound. A fault in the latency pipe appears at `rd_valid_o` exactly `CL` cycles after the affected read, as a strobe that is missing, early, late or duplicated.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } mem_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLOSE  = 2'd1,
        ST_OPEN   = 2'd2,
        ST_ACCESS = 2'd3
    } seq_st_e;

    localparam int NUM_GAPS = 4;
    localparam int GAP_WR  = 0;
    localparam int GAP_WTR = 1;
    localparam int GAP_RP  = 2;
    localparam int GAP_RCD = 3;

endpackage

// File: rtl/sdram_gap_timer.sv
// Loadable down-counter. Armed in the cycle a command is chosen, it reports
// open one cycle before the earliest legal issue cycle of a dependent command.
module sdram_gap_timer #(
    parameter int GAP = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    output logic open_o
);
    localparam int CW = (GAP < 2) ? 1 : $clog2(GAP + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (arm_i) begin
            cnt_d = CW'(GAP);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign open_o = (cnt_q <= CW'(1));
endmodule

// File: rtl/sdram_rd_return.sv
// Delays the read-command marker by CL cycles and gates returned data.
module sdram_rd_return #(
    parameter int CL     = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_cmd_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [CL-1:0] pipe_d, pipe_q;

    generate
        if (CL == 1) begin : g_single
            assign pipe_d = rd_cmd_i;
        end else begin : g_chain
            assign pipe_d = {pipe_q[CL-2:0], rd_cmd_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rd_valid_o = pipe_q[CL-1];
    assign rd_data_o  = rd_valid_o ? mem_rdata_i : '0;
endmodule

// File: rtl/sdram_bank_seq.sv
module sdram_bank_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    parameter int T_WR   = 3,
    parameter int T_RP   = 2,
    parameter int T_RCD  = 2,
    parameter int T_WTR  = 4,
    parameter int CL     = 3
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   req_i,
    input  logic                   req_we_i,
    input  logic [ROW_W+COL_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0]      req_wdata_i,
    output logic                   ready_o,
    output logic [2:0]             cmd_o,
    output logic [ROW_W-1:0]       cmd_row_o,
    output logic [COL_W-1:0]       cmd_col_o,
    output logic [DATA_W-1:0]      cmd_wdata_o,
    input  logic [DATA_W-1:0]      mem_rdata_i,
    output logic                   rd_valid_o,
    output logic [DATA_W-1:0]      rd_data_o
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int GAP_LEN [NUM_GAPS] = '{T_WR, T_WTR, T_RP, T_RCD};

    typedef struct packed {
        seq_st_e           st;
        logic              we;
        logic              hit;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic              open_v;
        logic [ROW_W-1:0]  open_row;
        mem_cmd_e          cmd;
        logic [ROW_W-1:0]  cmd_row;
        logic [COL_W-1:0]  cmd_col;
        logic [DATA_W-1:0] cmd_wdata;
    } seq_s;

    seq_s s_d, s_q;

    logic [ROW_W-1:0]    req_row;
    logic [COL_W-1:0]    req_col;
    logic [NUM_GAPS-1:0] gap_arm;
    logic [NUM_GAPS-1:0] gap_open;

    assign req_row = req_addr_i[ADDR_W-1:COL_W];
    assign req_col = req_addr_i[COL_W-1:0];

    // Next-state computation
    always_comb begin
        s_d           = s_q;
        s_d.cmd       = CMD_NOP;
        s_d.cmd_row   = '0;
        s_d.cmd_col   = '0;
        s_d.cmd_wdata = '0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    s_d.we    = req_we_i;
                    s_d.row   = req_row;
                    s_d.col   = req_col;
                    s_d.wdata = req_wdata_i;
                    if (s_q.open_v && (s_q.open_row == req_row)) begin
                        s_d.hit = 1'b1;
                        s_d.st  = ST_ACCESS;
                    end else if (s_q.open_v) begin
                        s_d.hit = 1'b0;
                        s_d.st  = ST_CLOSE;
                    end else begin
                        s_d.hit = 1'b0;
                        s_d.st  = ST_OPEN;
                    end
                end
            end
            ST_CLOSE: begin
                if (gap_open[GAP_WR]) begin
                    s_d.cmd    = CMD_PRE;
                    s_d.open_v = 1'b0;
                    s_d.st     = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (gap_open[GAP_RP]) begin
                    s_d.cmd      = CMD_ACT;
                    s_d.cmd_row  = s_q.row;
                    s_d.open_v   = 1'b1;
                    s_d.open_row = s_q.row;
                    s_d.st       = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                // turnaround applies only when no precharge/activate chain preceded
                if (gap_open[GAP_RCD] &&
                    (s_q.we || !s_q.hit || gap_open[GAP_WTR])) begin
                    s_d.cmd     = s_q.we ? CMD_WR : CMD_RD;
                    s_d.cmd_col = s_q.col;
                    if (s_q.we) begin
                        s_d.cmd_wdata = s_q.wdata;
                    end
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Gap timers armed by the command being chosen
    assign gap_arm[GAP_WR]  = (s_d.cmd == CMD_WR);
    assign gap_arm[GAP_WTR] = (s_d.cmd == CMD_WR);
    assign gap_arm[GAP_RP]  = (s_d.cmd == CMD_PRE);
    assign gap_arm[GAP_RCD] = (s_d.cmd == CMD_ACT);

    generate
        for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
            sdram_gap_timer #(
                .GAP(GAP_LEN[g])
            ) u_timer (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .arm_i  (gap_arm[g]),
                .open_o (gap_open[g])
            );
        end
    endgenerate

    sdram_rd_return #(
        .CL    (CL),
        .DATA_W(DATA_W)
    ) u_ret (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_cmd_i   (s_q.cmd == CMD_RD),
        .mem_rdata_i(mem_rdata_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    assign ready_o     = (s_q.st == ST_IDLE);
    assign cmd_o       = s_q.cmd;
    assign cmd_row_o   = s_q.cmd_row;
    assign cmd_col_o   = s_q.cmd_col;
    assign cmd_wdata_o = s_q.cmd_wdata;
endmodule

// File: rtl/sdram_bank_seq_chk.sv
module sdram_bank_seq_chk #(
    parameter int T_WR  = 3,
    parameter int T_RP  = 2,
    parameter int T_RCD = 2,
    parameter int T_WTR = 4
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_i,
    input logic       ready_o,
    input logic [2:0] cmd_o
);
    localparam logic [2:0] C_PRE = 3'd1;
    localparam logic [2:0] C_ACT = 3'd2;
    localparam logic [2:0] C_RD  = 3'd3;
    localparam logic [2:0] C_WR  = 3'd4;

    logic [15:0] since_wr, since_pre, since_act;
    logic        open_q;

    function automatic logic [15:0] bump(input logic [15:0] v);
        return (v == 16'hFFFF) ? v : v + 16'd1;
    endfunction

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            since_wr  <= 16'hFFFF;
            since_pre <= 16'hFFFF;
            since_act <= 16'hFFFF;
            open_q    <= 1'b0;
        end else begin
            since_wr  <= (cmd_o == C_WR)  ? 16'd1 : bump(since_wr);
            since_pre <= (cmd_o == C_PRE) ? 16'd1 : bump(since_pre);
            since_act <= (cmd_o == C_ACT) ? 16'd1 : bump(since_act);
            if (cmd_o == C_ACT) open_q <= 1'b1;
            else if (cmd_o == C_PRE) open_q <= 1'b0;
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && ready_o) |=> !ready_o); // R1
    AST_ACT_ON_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == C_ACT) |-> !open_q); // R4
    AST_ACCESS_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == C_RD || cmd_o == C_WR) |-> open_q); // R5
    AST_PRE_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == C_PRE) |-> open_q); // R6
    AST_PRE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == C_PRE) |-> (since_wr >= 16'(T_WR))); // R7
    AST_ACT_AFTER_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == C_ACT) |-> (since_pre >= 16'(T_RP))); // R8
    AST_ACCESS_AFTER_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == C_RD || cmd_o == C_WR) |-> (since_act >= 16'(T_RCD))); // R9
    AST_HIT_READ_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == C_RD && since_wr < since_act) |-> (since_wr >= 16'(T_WTR))); // R10
endmodule

bind sdram_bank_seq sdram_bank_seq_chk #(
    .T_WR (T_WR),
    .T_RP (T_RP),
    .T_RCD(T_RCD),
    .T_WTR(T_WTR)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .ready_o(ready_o),
    .cmd_o  (cmd_o)
);

// File: tb/sdram_bank_seq_test.sv
module sdram_bank_seq_test;
    localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
    localparam int T_WR = 3, T_RP = 2, T_RCD = 2, T_WTR = 4, CL = 3;
    localparam int C_NOP = 0, C_PRE = 1, C_ACT = 2, C_RD = 3, C_WR = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic req, we;
    logic [7:0] addr, wdata;
    logic ready, rd_valid;
    logic [2:0] cmd;
    logic [3:0] cmd_row, cmd_col;
    logic [7:0] cmd_wdata, mem_rdata, rd_data;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int last_wr = -1000, last_pre = -1000, last_act = -1000;
    bit m_open = 0;
    int m_row = 0;
    int rdq[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign mem_rdata = 8'(cyc) ^ 8'hA5;

    sdram_bank_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_WR(T_WR), .T_RP(T_RP), .T_RCD(T_RCD), .T_WTR(T_WTR), .CL(CL)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(we),
        .req_addr_i(addr), .req_wdata_i(wdata), .ready_o(ready),
        .cmd_o(cmd), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
        .cmd_wdata_o(cmd_wdata), .mem_rdata_i(mem_rdata),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int mx(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // Read-return monitor: strobe exactly CL cycles after each read (R11)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rdq.size() > 0 && rdq[0] < cyc) begin
                chk(0, "R11 missing strobe", cyc, rdq[0]);
                void'(rdq.pop_front());
            end
            if (rd_valid) begin
                if (rdq.size() > 0 && rdq[0] == cyc) begin
                    chk(rd_data == mem_rdata, "R11 data", rd_data, mem_rdata);
                    void'(rdq.pop_front());
                end else begin
                    chk(0, "R11 unexpected strobe", cyc, (rdq.size() > 0) ? rdq[0] : -1);
                end
            end
            if (cmd == 3'(C_RD)) rdq.push_back(cyc + CL);
        end
    end

    task automatic run_req(input bit we_in, input logic [7:0] a_in,
                           input logic [7:0] d_in, input bit poke);
        int a, n, idx, row, col, t, pre_c, act_c, acc_c;
        int ecmd[3];
        int ecyc[3];
        string ctag[3];
        string ttag;
        bit hit, miss, ready_bad, done_l;

        while (!ready) @(negedge clk);
        row = int'(a_in[7:4]);
        col = int'(a_in[3:0]);
        req = 1'b1; we = we_in; addr = a_in; wdata = d_in;
        a = cyc;

        // expected command list from the timing rules
        t = a + 2; n = 0;
        hit = m_open && (m_row == row);
        miss = m_open && !hit;
        pre_c = -1000; act_c = -1000;
        if (hit) begin
            ttag = "R5";
            acc_c = mx(t, last_act + T_RCD);
            if (!we_in) acc_c = mx(acc_c, last_wr + T_WTR);
        end else begin
            if (miss) begin
                ttag = "R6";
                pre_c = mx(t, last_wr + T_WR);
                ecmd[n] = C_PRE; ecyc[n] = pre_c; ctag[n] = "R7/R12"; n++;
                act_c = pre_c + T_RP;
            end else begin
                ttag = "R4";
                act_c = mx(t, last_pre + T_RP);
            end
            ecmd[n] = C_ACT; ecyc[n] = act_c; ctag[n] = "R8/R12"; n++;
            acc_c = act_c + T_RCD;
        end
        ecmd[n] = we_in ? C_WR : C_RD; ecyc[n] = acc_c;
        ctag[n] = (hit && !we_in) ? "R10/R12" : "R9/R12"; n++;

        @(negedge clk);
        if (poke) begin
            addr = ~a_in; we = !we_in; wdata = ~d_in;
        end else begin
            req = 1'b0;
        end
        idx = 0; ready_bad = 0; done_l = 0;
        while (!done_l) begin
            if (cyc >= a + 2) req = 1'b0;
            if (cmd != 3'(C_NOP)) begin
                if (idx < n) begin
                    chk(int'(cmd) == ecmd[idx], ttag, int'(cmd), ecmd[idx]);
                    chk(cyc == ecyc[idx], ctag[idx], cyc, ecyc[idx]);
                    if (cmd == 3'(C_ACT))
                        chk(int'(cmd_row) == row, "R3 row", int'(cmd_row), row);
                    if (cmd == 3'(C_RD) || cmd == 3'(C_WR))
                        chk(int'(cmd_col) == col, "R3 col", int'(cmd_col), col);
                    if (cmd == 3'(C_WR))
                        chk(cmd_wdata == d_in, "R3 wdata", cmd_wdata, d_in);
                end else begin
                    chk(0, "R3 extra command", int'(cmd), C_NOP);
                end
                idx++;
                if (cmd == 3'(C_RD) || cmd == 3'(C_WR)) done_l = 1;
            end
            if (!done_l && ready) ready_bad = 1;
            if (cyc > a + 200) begin
                chk(0, "R12 no access issued", cyc, acc_c);
                done_l = 1;
            end
            if (!done_l) @(negedge clk);
        end
        req = 1'b0;
        chk(!ready_bad, "R1 ready while busy", ready_bad, 0);
        chk(ready == 1'b1, "R1 ready back", ready, 1);

        if (miss) begin last_pre = pre_c; m_open = 0; end
        if (!hit) begin last_act = act_c; m_open = 1; m_row = row; end
        if (we_in) last_wr = acc_c;
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R2 ready", ready, 1);
        chk(cmd == 3'(C_NOP), "R2 cmd", cmd, C_NOP);
        chk(rd_valid == 1'b0, "R2 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        run_req(1'b0, 8'h12, 8'h00, 1'b0);   // closed bank: R4
        run_req(1'b1, 8'h13, 8'h3C, 1'b0);   // hit write: R5
        run_req(1'b0, 8'h14, 8'h00, 1'b0);   // hit read after write: R10
        run_req(1'b1, 8'h15, 8'h77, 1'b0);
        run_req(1'b0, 8'h26, 8'h00, 1'b0);   // miss after write: R6 R7 R8 R9
        run_req(1'b0, 8'h27, 8'h00, 1'b1);   // request while busy ignored: R1
        run_req(1'b0, 8'h28, 8'h00, 1'b0);   // back-to-back reads: R11
        run_req(1'b1, 8'h39, 8'hE1, 1'b1);
        run_req(1'b0, 8'h3A, 8'h00, 1'b0);

        for (int i = 0; i < 400; i++) begin
            int gap;
            logic [7:0] ra;
            gap = int'($urandom % 3);
            repeat (gap) @(negedge clk);
            ra = {4'($urandom % 4), 4'($urandom)};
            run_req(1'($urandom), ra, 8'($urandom), ($urandom % 8) == 0);
        end

        // idle: no command without a request (R1), all reads returned (R11)
        begin
            bit quiet;
            quiet = 1;
            repeat (CL + 8) begin
                @(negedge clk);
                if (cmd != 3'(C_NOP)) quiet = 0;
            end
            chk(quiet, "R1 idle commands", !quiet, 0);
            chk(rdq.size() == 0, "R11 pending reads", rdq.size(), 0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected finished", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule